// File: doc/BRIEF.md
# Two-wire serial debug host engine

This block is the host side of a two-wire serial debug link. It has one clock line, which it always drives, and one bidirectional data line, which it drives through an output enable. A caller places a 4-bit request, a write word and the per-transfer settings on the inputs and pulses `start`. The engine then runs one complete transfer on the wire and pulses `done`. The settings are the turnaround length, the count of trailing idle clocks, the data-phase mode and the clock divider. The transfer is made of the request frame, a turnaround, a 3-bit acknowledge from the target, and then either a data phase or a recovery sequence chosen by that acknowledge.

The engine returns the raw acknowledge, the word read from the target, and a flag for a read parity mismatch. The wire clock rests high between transfers. Every wire clock period is built from a programmable number of system clocks. The host changes the data line only while the wire clock is low. It samples the target in the last system clock of the low phase, just ahead of the rising edge.

Top module: `dbg_wire_host`

## Requirements
- R1: Out of reset and whenever no transfer is running, `dclk_o` is 1, `dio_oe` is 1, `dio_o` is 1, and `busy` and `done` are 0.
- R2: A `start` pulse while idle begins a transfer, and `busy` is 1 from the next cycle on. `done` is a one-cycle pulse in the cycle where `busy` returns to 0. A `start` pulse while `busy` is ignored, and the inputs are latched at the accepted `start`.
- R3: Each transfer opens with 8 driven wire clocks carrying, in this order: 1, then `req[0]` to `req[3]`, then the even parity of `req[3:0]`, then 0, then 1. `req[1]`=1 selects a read and `req[1]`=0 selects a write.
- R4: After the request, the line is released (`dio_oe`=0) for `ta_cfg`+1 wire clocks of turnaround.
- R5: The 3 acknowledge bits are sampled on released clocks, first bit into bit 0. The result is reported on `ack_o`: 3'b001 is OK, 3'b010 is WAIT, 3'b100 is FAULT, and every other value is a protocol error.
- R6: On an OK read, 32 data bits (first into bit 0) and then a parity bit are sampled, followed by `ta_cfg`+1 released clocks. The data appears on `rd_word`. `par_err` is 1 exactly when the parity bit differs from the even parity of the data.
- R7: On an OK write, `ta_cfg`+1 released clocks come first. The host then drives `wr_word` bit 0 first for 32 clocks, followed by the even parity of `wr_word`.
- R8: After an OK transfer, the line is driven 0 for `idle_cfg` clocks. When the transfer ends, the line is driven 1.
- R9: On WAIT or FAULT with `dp_en`=1, 33 further clocks run. For a read, the line is released during them and `ta_cfg`+1 released clocks follow. For a write, the line is driven 0 during them.
- R10: On WAIT or FAULT with `dp_en`=0, `ta_cfg`+1 released clocks run and the transfer ends.
- R11: On a protocol error, `ta_cfg`+34 released clocks run and the transfer ends.
- R12: Each wire clock is `half_div`+1 system clocks low followed by `half_div`+1 high. `dio_o` and `dio_oe` change during a transfer only while `dclk_o` is 0. `done` arrives exactly (wire clocks × 2 × (`half_div`+1)) cycles after the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| req | input | 4 | Request: [0] port select, [1] read, [3:2] address |
| wr_word | input | DATA_W | Word to send on a write |
| ta_cfg | input | TA_W | Turnaround length minus one |
| idle_cfg | input | IDLE_W | Trailing low idle clocks after an OK transfer |
| dp_en | input | 1 | Run data-phase clocks after WAIT/FAULT |
| half_div | input | DIV_W | Wire clock half-period minus one, in system clocks |
| dclk_o | output | 1 | Wire clock, high at rest |
| dio_o | output | 1 | Data line drive value |
| dio_oe | output | 1 | Data line drive enable |
| dio_i | input | 1 | Data line as seen from the pin |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ack_o | output | 3 | Acknowledge of the last transfer |
| rd_word | output | DATA_W | Word from the last OK read |
| par_err | output | 1 | Parity mismatch on the last OK read |

## Verification
A bench-side target model follows the wire clock. It answers each transfer and records the line on every rising edge, and each recorded clock is compared with a sequence the bench builds from the request, the acknowledge and the settings. The corner cases it targets are these:
- Zero idle clocks and the longest turnaround. A design that miscounts either shifts or drops clocks, and the slot count and the cycle total both break.
- Unlisted acknowledge codes such as 000 and 111. A design that treated these as WAIT or OK would run the wrong recovery length.
- A write WAIT with data-phase mode on. A design that released the line here, instead of holding it low, would be caught on the recorded clocks.
- A flipped read parity bit, which must raise `par_err` without changing `rd_word`.
- A second `start` pulse with changed inputs during a transfer. A design that did not latch its inputs would change the frame mid-flight.

// File: rtl/dbgh_pkg.sv
package dbgh_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_TA1,
    ST_ACK,
    ST_RDAT,
    ST_TA2,
    ST_WDAT,
    ST_IDLC,
    ST_DUMMY,
    ST_ERR
  } seq_st_e;

  typedef enum logic [1:0] {
    AK_OK,
    AK_HOLD,
    AK_BAD
  } ack_cls_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam int         REQ_SLOTS = 8;

  // wire order is bit 0 first: start, r0..r3, parity, stop, park
  function automatic logic [REQ_SLOTS-1:0] req_frame(input logic [3:0] r);
    return {1'b1, 1'b0, ^r, r, 1'b1};
  endfunction

  function automatic ack_cls_e classify_ack(input logic [2:0] a);
    if (a == ACK_OK)                         return AK_OK;
    else if (a == ACK_WAIT || a == ACK_FAULT) return AK_HOLD;
    else                                     return AK_BAD;
  endfunction

endpackage

// File: rtl/dbgh_bit_timer.sv
module dbgh_bit_timer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             line_clk,
  output logic             samp_evt,
  output logic             slot_end
);

  logic             ph;
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == half_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      ph  <= 1'b0;
      cnt <= '0;
    end else if (at_end) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // low phase first in every slot; rest level is high
  assign line_clk = ~run | ph;
  assign samp_evt = run & ~ph & at_end;
  assign slot_end = run & ph & at_end;

endmodule

// File: rtl/dbgh_rx_shift.sv
module dbgh_rx_shift #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);

  // first sampled bit ends at the low end of the word
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {din, q[W-1:1]};
  end

endmodule

// File: rtl/dbgh_seq.sv
module dbgh_seq
  import dbgh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TA_W   = 2,
  parameter int IDLE_W = 4,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        req,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TA_W-1:0]   ta_cfg,
  input  logic [IDLE_W-1:0] idle_cfg,
  input  logic              dp_en,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              slot_end,
  input  logic              samp_evt,
  input  logic [DATA_W:0]   rx_q,
  output logic              busy,
  output logic              shift_en,
  output logic              drv_o,
  output logic              drv_oe,
  output logic              done,
  output logic [2:0]        ack_o,
  output logic [DATA_W-1:0] rd_word,
  output logic              par_err,
  output logic [DIV_W-1:0]  div_q,
  output logic [3:0]        req_q
);

  localparam int REM_A = $clog2(DATA_W + (1 << TA_W) + 1);
  localparam int REM_W = (REM_A > IDLE_W) ? REM_A : IDLE_W;

  seq_st_e                st, nxt_st;
  logic [REM_W-1:0]       rem, nxt_rem;
  logic                   fin;
  logic [TA_W-1:0]        ta_q;
  logic [IDLE_W-1:0]      idle_q;
  logic                   dp_q;
  logic                   ack_ok_q;
  logic [REQ_SLOTS-1:0]   frame_q;
  logic [DATA_W:0]        tx_q;
  logic [2:0]             ack_now;
  ack_cls_e               ack_cls;
  logic                   rnw;
  logic                   last_slot;

  assign rnw       = req_q[1];
  assign ack_now   = rx_q[DATA_W -: 3];
  assign ack_cls   = classify_ack(ack_now);
  assign busy      = (st != ST_IDLE);
  assign last_slot = slot_end && (rem == '0);
  assign shift_en  = samp_evt && (st == ST_ACK || st == ST_RDAT);

  // successor of the current phase once its last slot ends
  always_comb begin
    nxt_st  = st;
    nxt_rem = rem;
    fin     = 1'b0;
    unique case (st)
      ST_REQ: begin
        nxt_st  = ST_TA1;
        nxt_rem = REM_W'(ta_q);
      end
      ST_TA1: begin
        nxt_st  = ST_ACK;
        nxt_rem = REM_W'(2);
      end
      ST_ACK: begin
        unique case (ack_cls)
          AK_OK: begin
            nxt_st  = rnw ? ST_RDAT : ST_TA2;
            nxt_rem = rnw ? REM_W'(DATA_W) : REM_W'(ta_q);
          end
          AK_HOLD: begin
            nxt_st  = dp_q ? ST_DUMMY : ST_TA2;
            nxt_rem = dp_q ? REM_W'(DATA_W) : REM_W'(ta_q);
          end
          default: begin
            nxt_st  = ST_ERR;
            nxt_rem = REM_W'(ta_q) + REM_W'(DATA_W + 1);
          end
        endcase
      end
      ST_RDAT: begin
        nxt_st  = ST_TA2;
        nxt_rem = REM_W'(ta_q);
      end
      ST_TA2: begin
        if (ack_ok_q && !rnw) begin
          nxt_st  = ST_WDAT;
          nxt_rem = REM_W'(DATA_W);
        end else if (ack_ok_q && idle_q != '0) begin
          nxt_st  = ST_IDLC;
          nxt_rem = REM_W'(idle_q) - 1'b1;
        end else begin
          fin = 1'b1;
        end
      end
      ST_WDAT: begin
        if (idle_q != '0) begin
          nxt_st  = ST_IDLC;
          nxt_rem = REM_W'(idle_q) - 1'b1;
        end else begin
          fin = 1'b1;
        end
      end
      ST_DUMMY: begin
        if (rnw) begin
          nxt_st  = ST_TA2;
          nxt_rem = REM_W'(ta_q);
        end else begin
          fin = 1'b1;
        end
      end
      ST_IDLC: fin = 1'b1;
      ST_ERR:  fin = 1'b1;
      default: fin = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rem      <= '0;
      req_q    <= '0;
      ta_q     <= '0;
      idle_q   <= '0;
      dp_q     <= 1'b0;
      div_q    <= '0;
      ack_ok_q <= 1'b0;
      frame_q  <= '1;
      tx_q     <= '0;
      done     <= 1'b0;
      ack_o    <= '0;
      rd_word  <= '0;
      par_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          st      <= ST_REQ;
          rem     <= REM_W'(REQ_SLOTS - 1);
          req_q   <= req;
          ta_q    <= ta_cfg;
          idle_q  <= idle_cfg;
          dp_q    <= dp_en;
          div_q   <= div_cfg;
          frame_q <= req_frame(req);
          tx_q    <= {^wdata, wdata};
          par_err <= 1'b0;
        end
      end else if (slot_end) begin
        if (st == ST_REQ)  frame_q <= {1'b1, frame_q[REQ_SLOTS-1:1]};
        if (st == ST_WDAT) tx_q    <= {1'b0, tx_q[DATA_W:1]};
        if (!last_slot) begin
          rem <= rem - 1'b1;
        end else begin
          if (fin) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st  <= nxt_st;
            rem <= nxt_rem;
          end
          if (st == ST_ACK) begin
            ack_o    <= ack_now;
            ack_ok_q <= (ack_cls == AK_OK);
          end
          if (st == ST_RDAT) begin
            rd_word <= rx_q[DATA_W-1:0];
            par_err <= ^rx_q;
          end
        end
      end
    end
  end

  // line drive per phase; released phases park the value high
  always_comb begin
    drv_oe = 1'b0;
    drv_o  = 1'b1;
    unique case (st)
      ST_IDLE:  begin drv_oe = 1'b1; drv_o = 1'b1;       end
      ST_REQ:   begin drv_oe = 1'b1; drv_o = frame_q[0]; end
      ST_WDAT:  begin drv_oe = 1'b1; drv_o = tx_q[0];    end
      ST_IDLC:  begin drv_oe = 1'b1; drv_o = 1'b0;       end
      ST_DUMMY: begin drv_oe = ~rnw; drv_o = rnw;        end
      default:  begin drv_oe = 1'b0; drv_o = 1'b1;       end
    endcase
  end

endmodule

// File: rtl/dbg_wire_host.sv
module dbg_wire_host
  import dbgh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TA_W   = 2,
  parameter int IDLE_W = 4,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        req,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [TA_W-1:0]   ta_cfg,
  input  logic [IDLE_W-1:0] idle_cfg,
  input  logic              dp_en,
  input  logic [DIV_W-1:0]  half_div,
  output logic              dclk_o,
  output logic              dio_o,
  output logic              dio_oe,
  input  logic              dio_i,
  output logic              busy,
  output logic              done,
  output logic [2:0]        ack_o,
  output logic [DATA_W-1:0] rd_word,
  output logic              par_err
);

  localparam int RX_W = DATA_W + 1;

  logic             slot_end;
  logic             samp_evt;
  logic             shift_en;
  logic [RX_W-1:0]  rx_q;
  logic [DIV_W-1:0] div_q;
  logic [3:0]       req_q;

  dbgh_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .half_div (div_q),
    .line_clk (dclk_o),
    .samp_evt (samp_evt),
    .slot_end (slot_end)
  );

  dbgh_rx_shift #(.W(RX_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (dio_i),
    .q        (rx_q)
  );

  dbgh_seq #(
    .DATA_W (DATA_W),
    .TA_W   (TA_W),
    .IDLE_W (IDLE_W),
    .DIV_W  (DIV_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .req      (req),
    .wdata    (wr_word),
    .ta_cfg   (ta_cfg),
    .idle_cfg (idle_cfg),
    .dp_en    (dp_en),
    .div_cfg  (half_div),
    .slot_end (slot_end),
    .samp_evt (samp_evt),
    .rx_q     (rx_q),
    .busy     (busy),
    .shift_en (shift_en),
    .drv_o    (dio_o),
    .drv_oe   (dio_oe),
    .done     (done),
    .ack_o    (ack_o),
    .rd_word  (rd_word),
    .par_err  (par_err),
    .div_q    (div_q),
    .req_q    (req_q)
  );

endmodule

// File: rtl/dbgh_checker.sv
module dbgh_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       dclk_o,
  input logic       dio_o,
  input logic       dio_oe,
  input logic [2:0] ack_o,
  input logic       par_err,
  input logic [3:0] req_q,
  input logic       shift_en
);

  // R1: resting line state
  a_r1_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dclk_o && dio_oe && dio_o));

  // R2: done marks the fall of busy
  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2: latched request cannot move mid-transfer
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(req_q));

  // R12: line only moves while the wire clock is low
  a_r12_change_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ($changed(dio_o) || $changed(dio_oe))) |-> !dclk_o);

  // R5: host never samples a line it drives
  a_r5_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (!dio_oe && !dclk_o));

  // R6: parity error only follows an OK acknowledge
  a_r6_perr_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> (ack_o == 3'b001));

endmodule

bind dbg_wire_host dbgh_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .dclk_o   (dclk_o),
  .dio_o    (dio_o),
  .dio_oe   (dio_oe),
  .ack_o    (ack_o),
  .par_err  (par_err),
  .req_q    (req_q),
  .shift_en (shift_en)
);

// File: tb/sim_dbg_wire_host.sv
`timescale 1ns/1ps
module sim_dbg_wire_host;
  localparam int DW = 32, TW = 2, IW = 4, VW = 4, MAXS = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    req = '0;
  logic [DW-1:0] wd = '0;
  logic [TW-1:0] ta = '0;
  logic [IW-1:0] idl = '0;
  logic          dp = 1'b0;
  logic [VW-1:0] dv = '0;
  logic          dio_i = 1'b1;
  wire           dclk, dio_o, dio_oe, busy, done, perr;
  wire [2:0]     ack;
  wire [DW-1:0]  rdw;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbg_wire_host u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .wr_word(wd),
    .ta_cfg(ta), .idle_cfg(idl), .dp_en(dp), .half_div(dv),
    .dclk_o(dclk), .dio_o(dio_o), .dio_oe(dio_oe), .dio_i(dio_i),
    .busy(busy), .done(done), .ack_o(ack), .rd_word(rdw), .par_err(perr)
  );

  // expected wire clocks and target answers
  bit    e_oe [MAXS], e_o [MAXS], e_t [MAXS];
  string e_rq [MAXS];
  int    e_n;
  bit    g_oe [MAXS], g_o [MAXS];
  int    slot_k = -1;
  bit    mon_on = 1'b0;

  always @(negedge dclk) if (mon_on) begin
    slot_k = slot_k + 1;
    if (slot_k < MAXS) dio_i = e_t[slot_k];
  end

  always @(posedge dclk) if (mon_on && slot_k >= 0 && slot_k < MAXS) begin
    g_oe[slot_k] = dio_oe;
    g_o[slot_k]  = dio_o;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input bit oe, input bit o, input bit t, input string rq);
    if (e_n < MAXS) begin
      e_oe[e_n] = oe; e_o[e_n] = o; e_t[e_n] = t; e_rq[e_n] = rq;
    end
    e_n++;
  endtask

  task automatic plan(input logic [3:0] r, input logic [DW-1:0] w, input int t,
                      input int il, input bit d, input logic [2:0] a,
                      input logic [DW-1:0] rv, input bit fl);
    bit ok, hold;
    e_n = 0;
    ok   = (a == 3'b001);
    hold = (a == 3'b010) || (a == 3'b100);
    push(1, 1, 1, "R3");
    for (int i = 0; i < 4; i++) push(1, r[i], 1, "R3");
    push(1, r[0] ^ r[1] ^ r[2] ^ r[3], 1, "R3");
    push(1, 0, 1, "R3");
    push(1, 1, 1, "R3");
    for (int i = 0; i < t; i++) push(0, 1, 1, "R4");
    for (int i = 0; i < 3; i++) push(0, 1, a[i], "R5");
    if (ok && r[1]) begin
      for (int i = 0; i < DW; i++) push(0, 1, rv[i], "R6");
      push(0, 1, (^rv) ^ fl, "R6");
      for (int i = 0; i < t; i++) push(0, 1, 1, "R6");
      for (int i = 0; i < il; i++) push(1, 0, 1, "R8");
    end else if (ok) begin
      for (int i = 0; i < t; i++) push(0, 1, 1, "R7");
      for (int i = 0; i < DW; i++) push(1, w[i], 1, "R7");
      push(1, ^w, 1, "R7");
      for (int i = 0; i < il; i++) push(1, 0, 1, "R8");
    end else if (hold && d && r[1]) begin
      for (int i = 0; i < DW + 1; i++) push(0, 1, 0, "R9");
      for (int i = 0; i < t; i++) push(0, 1, 1, "R9");
    end else if (hold && d) begin
      for (int i = 0; i < DW + 1; i++) push(1, 0, 1, "R9");
    end else if (hold) begin
      for (int i = 0; i < t; i++) push(0, 1, 1, "R10");
    end else begin
      for (int i = 0; i < t + DW + 1; i++) push(0, 1, 0, "R11");
    end
  endtask

  task automatic xfer(input logic [3:0] r, input logic [DW-1:0] w, input int tc,
                      input int il, input bit d, input logic [2:0] a,
                      input logic [DW-1:0] rv, input bit fl, input int div,
                      input bit poke);
    int t_s, n, lim;
    plan(r, w, tc + 1, il, d, a, rv, fl);
    @(negedge clk);
    req = r; wd = w; ta = TW'(tc); idl = IW'(il); dp = d; dv = VW'(div);
    slot_k = -1; mon_on = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t_s = cyc;
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      req = ~r; wd = ~w; ta = ~ta; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 30000) begin
      @(negedge clk);
      n++;
    end
    mon_on = 1'b0;
    if (done !== 1'b1) begin
      chk(0, "R2", "done never seen", 0, 1);
    end else begin
      chk(cyc - t_s == e_n * 2 * (div + 1), "R12", "cycles to done",
          cyc - t_s, e_n * 2 * (div + 1));
      chk(busy === 1'b0, "R2", "busy low with done", busy, 0);
    end
    chk(slot_k + 1 == e_n, "R12", "wire clock count", slot_k + 1, e_n);
    lim = (slot_k + 1 < e_n) ? slot_k + 1 : e_n;
    if (lim > MAXS) lim = MAXS;
    for (int k = 0; k < lim; k++)
      chk(g_oe[k] == e_oe[k] && (!e_oe[k] || g_o[k] == e_o[k]), e_rq[k],
          $sformatf("slot %0d oe/o", k), {g_oe[k], g_o[k]}, {e_oe[k], e_o[k]});
    chk(ack === a, "R5", "ack_o", ack, a);
    if (a == 3'b001 && r[1]) begin
      chk(rdw === rv, "R6", "rd_word", rdw, rv);
      chk(perr === fl, "R6", "par_err", perr, fl);
    end else begin
      chk(perr === 1'b0, "R6", "par_err clear", perr, 0);
    end
    @(negedge clk);
    chk(done === 1'b0, "R2", "done one cycle", done, 0);
    chk(dclk && dio_oe && dio_o, "R8", "line high at rest",
        {dclk, dio_oe, dio_o}, 3'b111);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(busy === 1'b0, "R2", "no transfer from ignored start", busy, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] bad [5] = '{3'b000, 3'b011, 3'b101, 3'b110, 3'b111};
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(dclk && dio_oe && dio_o && !busy && !done, "R1", "reset state",
        {dclk, dio_oe, dio_o, busy, done}, 5'b11100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dclk && dio_oe && dio_o && !busy, "R1", "idle after reset",
        {dclk, dio_oe, dio_o, busy}, 4'b1110);

    xfer(4'b0010, '0, 0, 0, 0, 3'b001, 32'hA5C3_0F96, 0, 0, 0);
    xfer(4'b1001, 32'h1234_5678, 1, 3, 0, 3'b001, '0, 0, 1, 0);
    xfer(4'b0111, '0, 3, 15, 1, 3'b001, 32'h8000_0001, 1, 2, 0);
    xfer(4'b0100, 32'hFFFF_0000, 2, 5, 1, 3'b010, '0, 0, 0, 0);
    xfer(4'b1010, '0, 1, 5, 1, 3'b100, 32'h0, 0, 1, 0);
    xfer(4'b0010, '0, 0, 7, 0, 3'b010, '0, 0, 0, 0);
    xfer(4'b0001, 32'hDEAD_BEEF, 3, 2, 0, 3'b100, '0, 0, 0, 0);
    xfer(4'b1110, '0, 1, 1, 1, 3'b111, '0, 0, 0, 0);
    xfer(4'b0000, '0, 3, 1, 0, 3'b000, '0, 0, 1, 0);
    xfer(4'b0110, '0, 2, 4, 0, 3'b001, 32'h0F0F_1234, 0, 1, 1);

    for (int i = 0; i < 30; i++) begin
      logic [2:0] a;
      int sel;
      sel = $urandom % 8;
      if (sel < 4)       a = 3'b001;
      else if (sel == 4) a = 3'b010;
      else if (sel == 5) a = 3'b100;
      else               a = bad[$urandom % 5];
      xfer(4'($urandom), $urandom, $urandom % 4, $urandom % 16, 1'($urandom),
           a, $urandom, ($urandom % 4) == 0, $urandom % 4, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule